// File: doc/BRIEF.md
# Slot Hotplug Event and Eject Controller

This block records hot-insert and hot-remove events for up to 32 slots on a single bus and presents them to software as a small set of 32-bit registers. Each event leaves exactly one bit set across two bitmaps: one for inserted slots and one for removed slots. It also raises a one-cycle request to set the hotplug bit of the general-purpose event status word, which a separate interrupt block owns.

Software reads the bitmaps to find which slot changed and may overwrite either bitmap. To request removal of a slot, software writes a slot mask to the eject register. The block then issues a one-cycle eject pulse together with the index of the lowest set bit of that mask. A removable-slots register reports, as a read-only mask, which slots can be hot-swapped. That mask is captured from a static input while reset is held.

Top module: `slot_hp_ctrl`

## Requirements
- R1: Register offsets on `acc_addr` (byte addresses, 32-bit accesses): 0x0 is the inserted bitmap, 0x4 the removed bitmap, 0x8 the eject command and 0xC the removable mask. A read of any other offset returns zero, and so does a cycle that is not a read.
- R2: A hot insert (`evt_valid`=1, `evt_remove`=0, `evt_cold`=0) for slot s clears both bitmaps on the next clock edge and then sets only bit s of the inserted bitmap.
- R3: A hot remove (`evt_valid`=1, `evt_remove`=1) for slot s clears both bitmaps and sets only bit s of the removed bitmap. `evt_cold` has no effect on a removal.
- R4: Each hot insert or hot remove produces, in the cycle after the event edge, a one-cycle `gpe_set` word in which only bit 1 is set. In every other cycle `gpe_set` is zero.
- R5: A cold insert (`evt_valid`=1, `evt_remove`=0, `evt_cold`=1) leaves both bitmaps unchanged and produces no `gpe_set` pulse.
- R6: A 32-bit write to offset 0x0 or 0x4 replaces the whole inserted or removed bitmap with the written value.
- R7: A write to offset 0x8 whose value is non-zero produces `eject_pulse`=1 for exactly the cycle after the write edge. In that cycle `eject_slot` equals the index of the lowest set bit of the value. `eject_slot` holds its last value until the next pulse and resets to 0.
- R8: A write of zero to offset 0x8 produces no eject pulse. A read of offset 0x8 always returns zero.
- R9: The removable mask reads as the bitwise inverse of `fixed_slots` as sampled while `rst_n` was low. Later changes on `fixed_slots` and writes to offset 0xC leave it unchanged.
- R10: If a hot event and a software write to a bitmap occur on the same edge, the event's result wins in both bitmaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; samples `fixed_slots` |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte offset of the register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational from the current access |
| evt_valid | input | 1 | Hotplug event strobe |
| evt_remove | input | 1 | 1 = removal, 0 = insertion |
| evt_cold | input | 1 | Insertion of a device present at power-up |
| evt_slot | input | 5 | Slot number of the event |
| fixed_slots | input | 32 | Static mask of slots that are not hot-swappable |
| gpe_set | output | 16 | One-cycle set request for the event status word (bit 1) |
| eject_pulse | output | 1 | One-cycle eject request |
| eject_slot | output | 5 | Slot index of the last eject request |

## Verification
The assertions assume that `fixed_slots` is stable while `rst_n` is low. They also assume that `evt_slot` is below the slot count whenever `evt_valid` is high, and that address, data and strobes settle away from the clock edge. The stimulus changes `fixed_slots` only after reset has been released or while holding reset for a new capture. It draws slot numbers modulo 32 and drives every input one time unit after a rising edge. Random operations mix hot, cold and removal events, bitmap writes, eject masks with shifted lowest bits, zero ejects and reads of all sixteen offsets.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;

    // Byte offsets of the software-visible registers
    localparam int unsigned OFS_INSERTED  = 0;
    localparam int unsigned OFS_REMOVED   = 4;
    localparam int unsigned OFS_EJECT     = 8;
    localparam int unsigned OFS_REMOVABLE = 12;

    // Register selected by the current access
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_INSERTED,
        SEL_REMOVED,
        SEL_EJECT,
        SEL_REMOVABLE
    } hp_sel_e;

endpackage

// File: rtl/hp_reg_decode.sv
module hp_reg_decode
    import slot_hp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_SLOTS = 32
) (
    input  logic                 acc_valid_i,
    input  logic                 acc_write_i,
    input  logic [ADDR_W-1:0]    acc_addr_i,
    input  logic [NUM_SLOTS-1:0] inserted_i,
    input  logic [NUM_SLOTS-1:0] removed_i,
    input  logic [NUM_SLOTS-1:0] removable_i,
    output hp_sel_e              sel_o,
    output logic                 wr_inserted_o,
    output logic                 wr_removed_o,
    output logic                 wr_eject_o,
    output logic [DATA_W-1:0]    rdata_o
);

    logic do_wr;
    logic do_rd;

    always_comb begin
        do_wr = acc_valid_i && acc_write_i;
        do_rd = acc_valid_i && !acc_write_i;

        if (acc_addr_i == ADDR_W'(OFS_INSERTED)) begin
            sel_o = SEL_INSERTED;
        end else if (acc_addr_i == ADDR_W'(OFS_REMOVED)) begin
            sel_o = SEL_REMOVED;
        end else if (acc_addr_i == ADDR_W'(OFS_EJECT)) begin
            sel_o = SEL_EJECT;
        end else if (acc_addr_i == ADDR_W'(OFS_REMOVABLE)) begin
            sel_o = SEL_REMOVABLE;
        end else begin
            sel_o = SEL_NONE;
        end

        wr_inserted_o = do_wr && (sel_o == SEL_INSERTED);
        wr_removed_o  = do_wr && (sel_o == SEL_REMOVED);
        wr_eject_o    = do_wr && (sel_o == SEL_EJECT);

        rdata_o = '0;
        if (do_rd) begin
            case (sel_o)
                SEL_INSERTED:  rdata_o[NUM_SLOTS-1:0] = inserted_i;
                SEL_REMOVED:   rdata_o[NUM_SLOTS-1:0] = removed_i;
                SEL_REMOVABLE: rdata_o[NUM_SLOTS-1:0] = removable_i;
                default:       rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/hp_event_capture.sv
module hp_event_capture #(
    parameter int unsigned NUM_SLOTS  = 32,
    parameter int unsigned SLOT_W     = 5,
    parameter int unsigned GPE_W      = 16,
    parameter int unsigned GPE_HP_BIT = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid_i,
    input  logic                 evt_remove_i,
    input  logic                 evt_cold_i,
    input  logic [SLOT_W-1:0]    evt_slot_i,
    input  logic                 wr_inserted_i,
    input  logic                 wr_removed_i,
    input  logic [NUM_SLOTS-1:0] wr_data_i,
    output logic [NUM_SLOTS-1:0] inserted_o,
    output logic [NUM_SLOTS-1:0] removed_o,
    output logic [GPE_W-1:0]     gpe_set_o
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0] up;
        logic [NUM_SLOTS-1:0] down;
        logic                 gpe;
    } cap_state_t;

    cap_state_t st_d, st_q;

    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 hot_evt;
    logic                 hot_ins;
    logic                 hot_rem;

    // One decoder leg per slot
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_dec
        assign slot_hit[g] = (evt_slot_i == SLOT_W'(g));
    end

    always_comb begin
        hot_ins = evt_valid_i && !evt_remove_i && !evt_cold_i;
        hot_rem = evt_valid_i && evt_remove_i;
        hot_evt = hot_ins || hot_rem;

        st_d     = st_q;
        st_d.gpe = hot_evt;

        // Software writes first; a hot event on the same edge overrides them
        if (wr_inserted_i) begin
            st_d.up = wr_data_i;
        end
        if (wr_removed_i) begin
            st_d.down = wr_data_i;
        end

        if (hot_evt) begin
            st_d.up   = hot_ins ? slot_hit : '0;
            st_d.down = hot_rem ? slot_hit : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        inserted_o            = st_q.up;
        removed_o             = st_q.down;
        gpe_set_o             = '0;
        gpe_set_o[GPE_HP_BIT] = st_q.gpe;
    end

    // Hot insert leaves only the slot bit set in the inserted bitmap
    p_insert_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && !evt_remove_i && !evt_cold_i)
        |=> (inserted_o == (NUM_SLOTS'(1) << $past(evt_slot_i))) && (removed_o == '0));

    // Hot remove leaves only the slot bit set in the removed bitmap
    p_remove_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && evt_remove_i)
        |=> (removed_o == (NUM_SLOTS'(1) << $past(evt_slot_i))) && (inserted_o == '0));

    // Set requests touch only the hotplug bit, one per hot event
    p_gpe_only_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gpe_set_o != '0) |-> (gpe_set_o == (GPE_W'(1) << GPE_HP_BIT)));

    p_gpe_after_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && (evt_remove_i || !evt_cold_i)) |=> gpe_set_o[GPE_HP_BIT]);

    // Cold insert without a software write leaves everything as it was
    p_cold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && !evt_remove_i && evt_cold_i && !wr_inserted_i && !wr_removed_i)
        |=> $stable(inserted_o) && $stable(removed_o) && (gpe_set_o == '0));

    // Plain software write stores the full value
    p_sw_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_inserted_i && !evt_valid_i) |=> (inserted_o == $past(wr_data_i)));

endmodule

// File: rtl/hp_lsb_encoder.sv
module hp_lsb_encoder #(
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = 5
) (
    input  logic [W-1:0]     vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // Scan from the top so the lowest set bit is the last to land
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/hp_eject_gen.sv
module hp_eject_gen #(
    parameter int unsigned NUM_SLOTS = 32,
    parameter int unsigned SLOT_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eject_wr_i,
    input  logic [NUM_SLOTS-1:0] wdata_i,
    output logic                 eject_pulse_o,
    output logic [SLOT_W-1:0]    eject_slot_o
);

    typedef struct packed {
        logic              pulse;
        logic [SLOT_W-1:0] slot;
    } ej_state_t;

    ej_state_t st_d, st_q;

    logic              lsb_found;
    logic [SLOT_W-1:0] lsb_idx;

    hp_lsb_encoder #(
        .W     (NUM_SLOTS),
        .IDX_W (SLOT_W)
    ) u_lsb (
        .vec_i   (wdata_i),
        .found_o (lsb_found),
        .idx_o   (lsb_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = eject_wr_i && lsb_found;
        if (eject_wr_i && lsb_found) begin
            st_d.slot = lsb_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eject_pulse_o = st_q.pulse;
    assign eject_slot_o  = st_q.slot;

    // Non-zero eject: pulse with a slot whose bit was set and no lower bit set
    p_eject_lsb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eject_wr_i && (wdata_i != '0))
        |=> eject_pulse_o
            && ((($past(wdata_i) >> eject_slot_o) & NUM_SLOTS'(1)) == NUM_SLOTS'(1))
            && (($past(wdata_i) & ((NUM_SLOTS'(1) << eject_slot_o) - NUM_SLOTS'(1))) == '0));

    // Zero eject: no pulse
    p_eject_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eject_wr_i && (wdata_i == '0)) |=> !eject_pulse_o);

    // Pulse only after an eject write
    p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !eject_wr_i |=> !eject_pulse_o);

endmodule

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl
    import slot_hp_pkg::*;
#(
    parameter int unsigned NUM_SLOTS  = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned GPE_W      = 16,
    parameter int unsigned GPE_HP_BIT = 1,
    localparam int unsigned SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [DATA_W-1:0]    acc_wdata,
    output logic [DATA_W-1:0]    acc_rdata,
    input  logic                 evt_valid,
    input  logic                 evt_remove,
    input  logic                 evt_cold,
    input  logic [SLOT_W-1:0]    evt_slot,
    input  logic [NUM_SLOTS-1:0] fixed_slots,
    output logic [GPE_W-1:0]     gpe_set,
    output logic                 eject_pulse,
    output logic [SLOT_W-1:0]    eject_slot
);

    hp_sel_e              sel;
    logic                 wr_inserted;
    logic                 wr_removed;
    logic                 wr_eject;
    logic [NUM_SLOTS-1:0] inserted;
    logic [NUM_SLOTS-1:0] removed;
    logic [NUM_SLOTS-1:0] rmv_d, rmv_q;
    logic [NUM_SLOTS-1:0] wslots;

    assign wslots = acc_wdata[NUM_SLOTS-1:0];

    hp_reg_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_dec (
        .acc_valid_i   (acc_valid),
        .acc_write_i   (acc_write),
        .acc_addr_i    (acc_addr),
        .inserted_i    (inserted),
        .removed_i     (removed),
        .removable_i   (rmv_q),
        .sel_o         (sel),
        .wr_inserted_o (wr_inserted),
        .wr_removed_o  (wr_removed),
        .wr_eject_o    (wr_eject),
        .rdata_o       (acc_rdata)
    );

    hp_event_capture #(
        .NUM_SLOTS  (NUM_SLOTS),
        .SLOT_W     (SLOT_W),
        .GPE_W      (GPE_W),
        .GPE_HP_BIT (GPE_HP_BIT)
    ) u_cap (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_valid_i   (evt_valid),
        .evt_remove_i  (evt_remove),
        .evt_cold_i    (evt_cold),
        .evt_slot_i    (evt_slot),
        .wr_inserted_i (wr_inserted),
        .wr_removed_i  (wr_removed),
        .wr_data_i     (wslots),
        .inserted_o    (inserted),
        .removed_o     (removed),
        .gpe_set_o     (gpe_set)
    );

    hp_eject_gen #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_ej (
        .clk           (clk),
        .rst_n         (rst_n),
        .eject_wr_i    (wr_eject),
        .wdata_i       (wslots),
        .eject_pulse_o (eject_pulse),
        .eject_slot_o  (eject_slot)
    );

    // Removable mask: captured during reset, read-only afterwards
    always_comb begin
        rmv_d = rmv_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rmv_q <= ~fixed_slots;
        end else begin
            rmv_q <= rmv_d;
        end
    end

    // Writes to the removable register do not alter it
    p_rmv_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && (sel == SEL_REMOVABLE)) |=> $stable(rmv_q));

    // Eject register reads back zero
    p_eject_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && (acc_addr == ADDR_W'(OFS_EJECT))) |-> (acc_rdata == '0));

    // Unmapped offsets read zero
    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (acc_rdata == '0));

    // Event wins against a same-edge bitmap write
    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_remove && wr_inserted) |=> (inserted == '0));

endmodule

// File: tb/slot_hp_ctrl_bench.sv
module slot_hp_ctrl_bench;

    localparam int unsigned NS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        evt_valid = 1'b0;
    logic        evt_remove = 1'b0;
    logic        evt_cold = 1'b0;
    logic [4:0]  evt_slot = '0;
    logic [31:0] fixed_slots = 32'h0000_0011;
    logic [15:0] gpe_set;
    logic        eject_pulse;
    logic [4:0]  eject_slot;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] m_up, m_down, m_rmv;
    logic [4:0]  m_slot;

    always #2 clk = ~clk;

    slot_hp_ctrl u_slot_hp_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .acc_rdata   (acc_rdata),
        .evt_valid   (evt_valid),
        .evt_remove  (evt_remove),
        .evt_cold    (evt_cold),
        .evt_slot    (evt_slot),
        .fixed_slots (fixed_slots),
        .gpe_set     (gpe_set),
        .eject_pulse (eject_pulse),
        .eject_slot  (eject_slot)
    );

    function automatic int lsb_of(logic [31:0] v);
        for (int i = 0; i < 32; i++) begin
            if (v[i]) return i;
        end
        return -1;
    endfunction

    function automatic logic [31:0] exp_read(logic [3:0] a);
        case (a)
            4'h0:    return m_up;
            4'h4:    return m_down;
            4'hC:    return m_rmv;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        acc_valid = 1'b0; acc_write = 1'b0; evt_valid = 1'b0;
        evt_remove = 1'b0; evt_cold = 1'b0;
    endtask

    task automatic do_reset(logic [31:0] fixed);
        idle();
        fixed_slots = fixed;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        m_up = '0; m_down = '0; m_rmv = ~fixed; m_slot = '0;
    endtask

    task automatic rd(string tag, logic [3:0] a);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        #1 chk(tag, acc_rdata, exp_read(a));
        idle();
    endtask

    // Applies optional write and/or event on one edge, then checks the pulses
    task automatic step(bit do_wr, logic [3:0] a, logic [31:0] d,
                        bit ev, bit rem, bit cold, logic [4:0] s);
        bit hot;
        bit ej;
        acc_valid = do_wr; acc_write = do_wr; acc_addr = a; acc_wdata = d;
        evt_valid = ev; evt_remove = rem; evt_cold = cold; evt_slot = s;
        hot = ev && (rem || !cold);
        ej  = do_wr && (a == 4'h8) && (d != 0);
        if (do_wr && a == 4'h0) m_up = d;
        if (do_wr && a == 4'h4) m_down = d;
        if (hot) begin
            m_up   = rem ? 32'h0 : (32'h1 << s);
            m_down = rem ? (32'h1 << s) : 32'h0;
        end
        if (ej) m_slot = 5'(lsb_of(d));
        @(posedge clk);
        #1;
        chk(hot ? "R4 gpe pulse" : "R4/R5 gpe quiet", 32'(gpe_set), hot ? 32'h2 : 32'h0);
        chk(ej ? "R7 eject pulse" : "R8 no eject pulse", 32'(eject_pulse), 32'(ej));
        chk("R7 eject slot", 32'(eject_slot), 32'(m_slot));
        idle();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5107_00A1));
        do_reset(32'h0000_0011);

        // Reset state (R1, R9)
        chk("reset gpe", 32'(gpe_set), 32'h0);
        chk("reset eject", 32'(eject_pulse), 32'h0);
        rd("R1 reset inserted", 4'h0);
        rd("R1 reset removed", 4'h4);
        rd("R9 removable after reset", 4'hC);
        chk("R9 removable value", acc_rdata, 32'hFFFF_FFEE);

        // R9: input changes and writes after reset are ignored
        fixed_slots = 32'hFFFF_0000;
        step(1, 4'hC, 32'h0, 0, 0, 0, 5'd0);
        rd("R9 removable unchanged", 4'hC);

        // R2 / R3 / R5 directed
        step(0, 4'h0, 0, 1, 0, 0, 5'd31);
        rd("R2 inserted slot 31", 4'h0);
        rd("R2 removed cleared", 4'h4);
        step(0, 4'h0, 0, 1, 1, 0, 5'd0);
        rd("R3 removed slot 0", 4'h4);
        rd("R3 inserted cleared", 4'h0);
        step(0, 4'h0, 0, 1, 1, 1, 5'd7);
        rd("R3 cold flag ignored on remove", 4'h4);
        step(0, 4'h0, 0, 1, 0, 1, 5'd9);
        rd("R5 cold insert keeps inserted", 4'h0);
        rd("R5 cold insert keeps removed", 4'h4);

        // R6 full writes
        step(1, 4'h0, 32'hA5A5_5A5A, 0, 0, 0, 0);
        rd("R6 inserted write", 4'h0);
        step(1, 4'h4, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd("R6 removed write", 4'h4);

        // R10 event vs write
        step(1, 4'h0, 32'hFFFF_FFFF, 1, 1, 0, 5'd3);
        rd("R10 event beats inserted write", 4'h0);
        rd("R10 removed from event", 4'h4);

        // R7 / R8 directed
        step(1, 4'h8, 32'h8000_0000, 0, 0, 0, 0);
        step(1, 4'h8, 32'hF0F0_0100, 0, 0, 0, 0);
        step(1, 4'h8, 32'h0, 0, 0, 0, 0);
        step(1, 4'h8, 32'h0000_0001, 0, 0, 0, 0);
        rd("R8 eject reads zero", 4'h8);

        // R1 unmapped offsets
        for (int a = 0; a < 16; a++) rd("R1 offset decode", 4'(a));

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op = $urandom % 6;
            logic [31:0] v = $urandom;
            logic [4:0]  s = 5'($urandom % NS);
            case (op)
                0: step(0, 4'h0, 0, 1, 0, ($urandom % 4) == 0, s);
                1: step(0, 4'h0, 0, 1, 1, $urandom % 2, s);
                2: step(1, ($urandom % 2) ? 4'h0 : 4'h4, v, $urandom % 3 == 0, $urandom % 2, 0, s);
                3: step(1, 4'h8, ($urandom % 5 == 0) ? 32'h0 : (v << ($urandom % 32)), 0, 0, 0, 0);
                4: step(1, 4'(($urandom % 16)), v, 0, 0, 0, 0);
                default: rd("R1 random read", 4'(($urandom % 16)));
            endcase
            rd("R2/R3/R6 inserted", 4'h0);
            rd("R2/R3/R6 removed", 4'h4);
        end
        rd("R9 removable after random writes", 4'hC);

        // R9 new capture on second reset
        do_reset(32'h8000_0001);
        fixed_slots = 32'h0;
        rd("R9 recapture", 4'hC);
        chk("R7 slot reset", 32'(eject_slot), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule